// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts

This block is a 64-deep byte queue shared by a host and an internal engine. One side pushes bytes, the other pops them, and both can observe the current fill level. The head byte is always presented on the read bus. When the queue is empty, the read bus shows zero.

A programmable watermark drives two alert flags. The low alert warns that the queue is nearly drained. The high alert warns that little free space remains.

A push that finds the queue full is dropped and latches an overflow error. The error stays set until a flush strobe. The flush strobe empties the queue and clears the error in the same cycle.

Top module: `byte_fifo_wm`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, the overflow error is 0 and `rd_data` is 0x00.
- R2: An accepted push without a pop raises the level by one. A pop without a push on a non-empty queue lowers it by one. Bytes leave in the order they entered, and `rd_data` always shows the oldest byte.
- R3: A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged. The popped byte is the old head.
- R4: A push alone while the level is 64 is discarded. The level stays 64 and the stored bytes are unchanged.
- R5: A discarded push sets `ovf_err`. The flag stays 1 through later pushes and pops until a flush.
- R6: A pop on an empty queue leaves the level at 0, and `rd_data` reads 0x00 while empty.
- R7: A flush returns the level to 0 and clears `ovf_err` at the next edge. It overrides any push or pop in the same cycle.
- R8: `hi_alert` is 1 exactly when (64 − level) ≤ watermark. It follows the level and watermark with no extra cycle (watermark 4: level 60 gives 1, level 59 gives 0).
- R9: `lo_alert` is 1 exactly when level ≤ watermark, with no extra cycle (watermark 4: level 4 gives 1, level 5 gives 0).
- R10: A push together with a pop at level 64 is accepted. The level stays 64, `ovf_err` is not set, and the pushed byte later leaves in order.
- R11: The storage indices wrap around, so ordering and data hold across more than 64 total pushes.
- R12: A push together with a pop on an empty queue stores the byte. The level becomes 1 and the pop has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| pop | input | 1 | Read strobe; consumes the head byte |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| flush | input | 1 | Strobe that empties the queue and clears the error |
| wmark | input | 6 | Watermark threshold |
| level | output | 7 | Bytes stored, 0 to 64 |
| empty | output | 1 | Level is 0 |
| full | output | 1 | Level is 64 |
| hi_alert | output | 1 | Free space at or below the watermark |
| lo_alert | output | 1 | Fill level at or below the watermark |
| ovf_err | output | 1 | Sticky error: a push was dropped |

## Verification
The hardest states to reach are those at full capacity. These are the push-with-pop at level 64 and the dropped push. Both need the queue driven through every level from empty to 64, with the watermark set so that the high alert switches between 59 and 60. The stimulus fills the queue one byte at a time, checking each level, and then applies the boundary cycles. A later long stream of mixed pushes and pops carries the storage indices around the array several times, so the wrap is checked against a reference queue held in the bench.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;

  // Free space compared against the watermark.
  function automatic logic space_alert(input int unsigned lvl,
                                       input int unsigned wm,
                                       input int unsigned depth);
    return (depth - lvl) <= wm;
  endfunction

  // Fill level compared against the watermark.
  function automatic logic fill_alert(input int unsigned lvl,
                                      input int unsigned wm);
    return lvl <= wm;
  endfunction

  // Index advance with explicit wrap, valid for any depth.
  function automatic int unsigned next_index(input int unsigned idx,
                                             input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/bfifo_store.sv
module bfifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             ovf_err
);
  logic push_ok, pop_ok, push_drop;
  logic [LVL_W-1:0] level_nxt;

  assign empty     = (level == '0);
  assign full      = (level == LVL_W'(DEPTH));
  assign pop_ok    = pop & ~empty & ~flush;
  assign push_ok   = push & ~flush & (~full | pop_ok);
  assign push_drop = push & ~flush & full & ~pop_ok;
  assign wr_en     = push_ok;

  always_comb begin
    level_nxt = level;
    if (flush) level_nxt = '0;
    else if (push_ok && !pop_ok) level_nxt = level + 1'b1;
    else if (pop_ok && !push_ok) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      ovf_err <= 1'b0;
    end else begin
      level <= level_nxt;
      if (flush) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        ovf_err <= 1'b0;
      end else begin
        if (push_ok) wr_ptr <= PTR_W'(next_index(int'(wr_ptr), DEPTH));
        if (pop_ok)  rd_ptr <= PTR_W'(next_index(int'(rd_ptr), DEPTH));
        if (push_drop) ovf_err <= 1'b1;
      end
    end
  end

  // R2
  lvl_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && !full) |=> (level == $past(level) + 1'b1));
  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush && !full && !empty) |=> $stable(level));
  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && full) |=> (full && $stable(wr_ptr)));
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !flush) |=> ovf_err);
  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !flush) |=> (empty && $stable(rd_ptr)));
  // R7
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !ovf_err && wr_ptr == rd_ptr));
  // R1
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
endmodule

// File: rtl/bfifo_alert.sv
module bfifo_alert
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int WM_W  = $clog2(DEPTH)
) (
  input  logic [LVL_W-1:0] level,
  input  logic [WM_W-1:0]  wmark,
  output logic             hi_alert,
  output logic             lo_alert
);
  assign hi_alert = space_alert(int'(level), int'(wmark), DEPTH);
  assign lo_alert = fill_alert(int'(level), int'(wmark));
endmodule

// File: rtl/byte_fifo_wm.sv
module byte_fifo_wm #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  input  logic             flush,
  input  logic [PTR_W-1:0] wmark,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             hi_alert,
  output logic             lo_alert,
  output logic             ovf_err
);
  logic             wr_en;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [WIDTH-1:0] head;

  bfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level),
    .empty(empty), .full(full), .ovf_err(ovf_err)
  );

  bfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(head)
  );

  bfifo_alert #(.DEPTH(DEPTH)) u_alert (
    .level(level), .wmark(wmark), .hi_alert(hi_alert), .lo_alert(lo_alert)
  );

  assign rd_data = empty ? '0 : head;

  // R6
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rd_data == '0));
  // R8
  full_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> hi_alert);
  // R9
  empty_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> lo_alert);
  // R10
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !flush && !ovf_err) |=> (full && !ovf_err));
endmodule

// File: tb/byte_fifo_wm_bench.sv
module byte_fifo_wm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [5:0] wmark = 6'd4;
  logic [7:0] rd_data;
  logic [6:0] level;
  logic       empty, full, hi_alert, lo_alert, ovf_err;

  int n_chk = 0, n_bad = 0;
  byte unsigned q[$];
  bit ovf_m = 0;

  always #2 clk = ~clk;

  byte_fifo_wm u_byte_fifo_wm (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .flush(flush), .wmark(wmark), .level(level),
    .empty(empty), .full(full), .hi_alert(hi_alert), .lo_alert(lo_alert),
    .ovf_err(ovf_err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int lv = q.size();
    chk(tag, "level", level, lv);
    chk(tag, "rd_data", rd_data, (lv == 0) ? 0 : q[0]);
    chk(tag, "ovf_err", ovf_err, ovf_m);
    chk(tag, "hi_alert", hi_alert, (lv + wmark >= 64) ? 1 : 0);
    chk(tag, "lo_alert", lo_alert, (wmark >= lv) ? 1 : 0);
    chk(tag, "empty", empty, lv == 0);
    chk(tag, "full", full, lv == 64);
  endtask

  // one cycle of stimulus; called with the clock low, returns at the next falling edge
  task automatic step(bit p, byte unsigned d, bit r, bit f, string tag);
    bit took_pop;
    push = p; wr_data = d; pop = r; flush = f;
    @(negedge clk);
    push = 0; pop = 0; flush = 0;
    if (f) begin
      q.delete(); ovf_m = 0;
    end else begin
      took_pop = r && q.size() > 0;
      if (took_pop) void'(q.pop_front());
      if (p) begin
        if (q.size() < 64) q.push_back(d);
        else ovf_m = 1;
      end
    end
    check_all(tag);
  endtask

  task automatic t_reset();
    check_all("R1");
  endtask

  task automatic t_order();
    for (int i = 0; i < 10; i++) step(1, 8'h10 + i, 0, 0, "R2");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, "R2");
  endtask

  task automatic t_simul();
    for (int i = 0; i < 3; i++) step(1, 8'hA0 + i, 0, 0, "R3");
    for (int i = 0; i < 5; i++) step(1, 8'hB0 + i, 1, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R3");
  endtask

  task automatic t_empty();
    step(0, 0, 1, 0, "R6");
    step(0, 0, 1, 0, "R6");
    step(1, 8'h5A, 1, 0, "R12");
    step(0, 0, 1, 0, "R12");
  endtask

  task automatic t_full();
    wmark = 6'd4;
    for (int i = 0; i < 64; i++) step(1, 8'(i * 3 + 1), 0, 0, "R8");
    step(1, 8'hEE, 1, 0, "R10");
    step(1, 8'hCC, 0, 0, "R4");
    chk("R5", "ovf set", ovf_err, 1);
    step(1, 8'hCD, 0, 0, "R4");
    for (int i = 0; i < 70; i++) step(0, 0, 1, 0, "R5");
    chk("R5", "ovf sticky", ovf_err, 1);
  endtask

  task automatic t_flush();
    step(1, 8'h11, 0, 0, "R7");
    step(1, 8'h22, 0, 0, "R7");
    step(1, 8'h33, 1, 1, "R7");
    chk("R7", "ovf cleared", ovf_err, 0);
    step(1, 8'h44, 0, 0, "R7");
    step(0, 0, 1, 0, "R7");
  endtask

  task automatic t_alerts();
    for (int w = 0; w < 64; w += 21) begin
      wmark = 6'(w);
      step(0, 0, 0, 1, "R9");
      for (int i = 0; i < 64; i++) step(1, 8'(i), 0, 0, "R8");
      for (int i = 0; i < 64; i++) step(0, 0, 1, 0, "R9");
    end
    wmark = 6'd63;
    #1 check_all("R8");
  endtask

  task automatic t_wrap();
    step(0, 0, 0, 1, "R11");
    for (int i = 0; i < 40; i++) step(1, 8'(i + 100), 0, 0, "R11");
    for (int i = 0; i < 150; i++) step(1, 8'(i * 7), 1, 0, "R11");
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0, "R11");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_simul();
    t_empty();
    t_full();
    t_flush();
    t_alerts();
    t_wrap();
    finish_run();
  end
endmodule